// File: doc/BRIEF.md
# Multiplexed Handshake Bus Slave Interface

This block is the slave end of a 16-bit multiplexed address/data bus driven by a single master. A mode line tells the bus whether the shared word lines carry address or data. Every address word is acknowledged by every slave, whether or not it is addressed, so the shared acknowledge completes only when the slowest slave responds. A select takes two address words. The first word carries the top eight bits of a 24-bit start address, a 4-bit device number, a memory/register space flag and the transfer direction. The second word carries the low sixteen bits of the start address. A slave whose own device number matches becomes selected. Device number 15 is a broadcast deselect that sends every slave back to idle.

Once selected and with the bus in data mode, the slave serves a run of transfers. On writes it listens: it takes the word on the master's data-ready strobe and answers with its data acknowledge. On reads it talks: it fetches a word from local storage, drives it with its own data-ready strobe, and removes both when the master acknowledges. Behind the bus side sits a simple local port with an address that counts up by one per accepted transfer. A wait input lets the local storage stall the handshake.

The control is one state machine with these states. IDLE waits for a first address word. ACK_W1 and ACK_W2 hold the address acknowledge. WAIT_W2 waits for the second word. ARMED means selected while the bus is still in address mode. SEL means selected in data mode. WR_STORE and WR_ACK serve a write. RD_FETCH, RD_DRIVE and RD_HOLD serve a read.

The transitions are:
- IDLE→ACK_W1 on an address strobe.
- ACK_W1→WAIT_W2 when the strobe drops.
- WAIT_W2→ACK_W2 on the next address strobe.
- ACK_W2→ARMED (match) or →IDLE (no match or deselect) when the strobe drops.
- ARMED→SEL when the mode line goes to data, or ARMED→ACK_W1 on a new address word.
- SEL→IDLE when the mode line returns to address.
- SEL→WR_STORE on a write strobe, then WR_STORE→WR_ACK when not waiting, then WR_ACK→SEL when the strobe drops.
- SEL→RD_FETCH in read direction, then RD_FETCH→RD_DRIVE when not waiting, or RD_FETCH→IDLE on address mode.
- RD_DRIVE→RD_HOLD on the master's acknowledge, then RD_HOLD→SEL when that acknowledge drops.

Top module: `mbs_slave`

## Requirements
- R1: For every word presented while `addr_mode` is 1 with `drdy_in` high, `aacc_out` rises one cycle later for any device number. It stays high while `drdy_in` stays high and falls one cycle after `drdy_in` goes low.
- R2: A slave becomes selected only after both address words have been acknowledged. After the first word alone, data strobes get no acknowledge.
- R3: Word 1 bits 7:4 hold the device number. A value equal to `dev_id` selects the slave. Any other value leaves it unselected. Value 15 deselects every slave.
- R4: Word 1 bit 1 is the space flag (0 memory, 1 register) and appears on `loc_space`. Word 1 bit 0 is the direction (0 = data into the slave). The start address is word 1 bits 15:8 followed by all 16 bits of word 2.
- R5: In write direction the selected slave captures `ad_in` on `drdy_in` and asserts `loc_wr` with that data. It raises `dacc_out` two cycles after the strobe when not waiting, and holds `dacc_out` until `drdy_in` goes low.
- R6: In read direction the selected slave drives the fetched word on `ad_out` with `ad_oe` and `drdy_out` high. Both stay, with stable data, until `dacc_in` is seen, and both fall one cycle later.
- R7: Returning `addr_mode` to 1 ends data mode. Data strobes that follow without a new select are not acknowledged.
- R8: `loc_addr` starts at the start address and increases by one after each accepted transfer.
- R9: While `loc_wait` is 1, `loc_wr` or `loc_rd` stays asserted with a stable address, and `dacc_out` or `drdy_out` is held back.
- R10: After reset all of `aacc_out`, `dacc_out`, `drdy_out`, `ad_oe`, `loc_wr` and `loc_rd` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all bus inputs are synchronous to it |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_id | input | 4 | This slave's device number (0..14) |
| ad_in | input | 16 | Multiplexed address/data word from the bus |
| ad_out | output | 16 | Read data driven by the slave |
| ad_oe | output | 1 | Enable for `ad_out` onto the bus |
| addr_mode | input | 1 | 1 = address mode, 0 = data mode |
| drdy_in | input | 1 | Master's data-ready strobe |
| drdy_out | output | 1 | Slave's data-ready strobe in reads |
| aacc_out | output | 1 | Address acknowledge (open-drain enable) |
| dacc_in | input | 1 | Master's data acknowledge in reads |
| dacc_out | output | 1 | Slave's data acknowledge in writes |
| loc_addr | output | 24 | Local storage address |
| loc_space | output | 1 | 0 memory, 1 register space |
| loc_wr | output | 1 | Local write request |
| loc_wdata | output | 16 | Local write data |
| loc_rd | output | 1 | Local read request |
| loc_rdata | input | 16 | Local read data, valid when not waiting |
| loc_wait | input | 1 | Local storage not ready |

## Verification
Bench inputs change on the falling edge, and outputs are read at a falling edge.
- An address strobe must be answered at the very next falling edge, and the acknowledge must be gone one edge after the strobe drops.
- A write acknowledge is due exactly two edges after the write strobe.
- A read data-ready strobe is awaited with a bounded loop, and must clear at the first edge after the master's acknowledge.
- Ignored strobes are held for a fixed window with no acknowledge allowed and no local write recorded.
- Local writes are logged at the rising edge, so address and data are compared after each handshake ends.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
    localparam int unsigned BUS_W     = 16;
    localparam int unsigned ADDR_W    = 24;
    localparam int unsigned DEV_W     = 4;
    localparam int unsigned HI_W      = ADDR_W - BUS_W;
    localparam int unsigned DEV_LSB   = 4;
    localparam int unsigned SPACE_BIT = 1;
    localparam int unsigned DIR_BIT   = 0;
    localparam logic [DEV_W-1:0] DESEL_ID = DEV_W'((1 << DEV_W) - 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ACK_W1,
        ST_WAIT_W2,
        ST_ACK_W2,
        ST_ARMED,
        ST_SEL,
        ST_WR_STORE,
        ST_WR_ACK,
        ST_RD_FETCH,
        ST_RD_DRIVE,
        ST_RD_HOLD
    } mbs_state_e;
endpackage

// File: rtl/mbs_word_latch.sv
module mbs_word_latch
    import mbs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_w1,
    input  logic [HI_W-1:0]  w1_hi,
    input  logic [DEV_W-1:0] w1_dev,
    input  logic             w1_space,
    input  logic             w1_dir,
    input  logic [DEV_W-1:0] dev_id,
    output logic [HI_W-1:0]  addr_hi,
    output logic             space,
    output logic             dir_rd,
    output logic             hit
);
    logic [DEV_W-1:0] dev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dev_q   <= DESEL_ID;
            addr_hi <= '0;
            space   <= 1'b0;
            dir_rd  <= 1'b0;
        end else if (cap_w1) begin
            dev_q   <= w1_dev;
            addr_hi <= w1_hi;
            space   <= w1_space;
            dir_rd  <= w1_dir;
        end
    end

    // Broadcast deselect never matches, whatever the own number is.
    assign hit = (dev_q == dev_id) && (dev_q != DESEL_ID);
endmodule

// File: rtl/mbs_addr_ctr.sv
module mbs_addr_ctr #(
    parameter int unsigned WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             inc,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= load_val;
        else if (inc)
            q <= q + WIDTH'(1);
    end
endmodule

// File: rtl/mbs_fsm.sv
module mbs_fsm
    import mbs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic addr_mode,
    input  logic drdy_in,
    input  logic dacc_in,
    input  logic loc_wait,
    input  logic hit,
    input  logic dir_rd,
    output logic aacc,
    output logic dacc,
    output logic drdy_o,
    output logic oe,
    output logic loc_wr,
    output logic loc_rd,
    output logic cap_w1,
    output logic cap_w2,
    output logic cap_wr,
    output logic cap_rd,
    output logic inc
);
    mbs_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        aacc    = 1'b0;
        dacc    = 1'b0;
        drdy_o  = 1'b0;
        oe      = 1'b0;
        loc_wr  = 1'b0;
        loc_rd  = 1'b0;
        cap_w1  = 1'b0;
        cap_w2  = 1'b0;
        cap_wr  = 1'b0;
        cap_rd  = 1'b0;
        inc     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (addr_mode && drdy_in) begin
                    cap_w1  = 1'b1;
                    state_d = ST_ACK_W1;
                end
            end
            ST_ACK_W1: begin
                aacc = 1'b1;
                if (!drdy_in) state_d = ST_WAIT_W2;
            end
            ST_WAIT_W2: begin
                if (addr_mode && drdy_in) begin
                    cap_w2  = 1'b1;
                    state_d = ST_ACK_W2;
                end
            end
            ST_ACK_W2: begin
                aacc = 1'b1;
                if (!drdy_in) state_d = hit ? ST_ARMED : ST_IDLE;
            end
            ST_ARMED: begin
                if (addr_mode && drdy_in) begin
                    cap_w1  = 1'b1;
                    state_d = ST_ACK_W1;
                end else if (!addr_mode) begin
                    state_d = ST_SEL;
                end
            end
            ST_SEL: begin
                if (addr_mode) begin
                    state_d = ST_IDLE;
                end else if (!dir_rd && drdy_in) begin
                    cap_wr  = 1'b1;
                    state_d = ST_WR_STORE;
                end else if (dir_rd) begin
                    state_d = ST_RD_FETCH;
                end
            end
            ST_WR_STORE: begin
                loc_wr = 1'b1;
                if (!loc_wait) state_d = ST_WR_ACK;
            end
            ST_WR_ACK: begin
                dacc = 1'b1;
                if (!drdy_in) begin
                    inc     = 1'b1;
                    state_d = ST_SEL;
                end
            end
            ST_RD_FETCH: begin
                loc_rd = 1'b1;
                if (addr_mode) begin
                    state_d = ST_IDLE;
                end else if (!loc_wait) begin
                    cap_rd  = 1'b1;
                    state_d = ST_RD_DRIVE;
                end
            end
            ST_RD_DRIVE: begin
                drdy_o = 1'b1;
                oe     = 1'b1;
                if (dacc_in) begin
                    inc     = 1'b1;
                    state_d = ST_RD_HOLD;
                end
            end
            ST_RD_HOLD: begin
                if (!dacc_in) state_d = ST_SEL;
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/mbs_slave.sv
module mbs_slave
    import mbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DEV_W-1:0]  dev_id,
    input  logic [BUS_W-1:0]  ad_in,
    output logic [BUS_W-1:0]  ad_out,
    output logic              ad_oe,
    input  logic              addr_mode,
    input  logic              drdy_in,
    output logic              drdy_out,
    output logic              aacc_out,
    input  logic              dacc_in,
    output logic              dacc_out,
    output logic [ADDR_W-1:0] loc_addr,
    output logic              loc_space,
    output logic              loc_wr,
    output logic [BUS_W-1:0]  loc_wdata,
    output logic              loc_rd,
    input  logic [BUS_W-1:0]  loc_rdata,
    input  logic              loc_wait
);
    logic            hit, dir_rd;
    logic [HI_W-1:0] addr_hi;
    logic            cap_w1, cap_w2, cap_wr, cap_rd, inc;
    logic [BUS_W-1:0] rdata_q;

    mbs_word_latch u_wl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_w1   (cap_w1),
        .w1_hi    (ad_in[BUS_W-1 -: HI_W]),
        .w1_dev   (ad_in[DEV_LSB +: DEV_W]),
        .w1_space (ad_in[SPACE_BIT]),
        .w1_dir   (ad_in[DIR_BIT]),
        .dev_id   (dev_id),
        .addr_hi  (addr_hi),
        .space    (loc_space),
        .dir_rd   (dir_rd),
        .hit      (hit)
    );

    mbs_addr_ctr #(.WIDTH(ADDR_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cap_w2),
        .load_val ({addr_hi, ad_in}),
        .inc      (inc),
        .q        (loc_addr)
    );

    mbs_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_mode (addr_mode),
        .drdy_in   (drdy_in),
        .dacc_in   (dacc_in),
        .loc_wait  (loc_wait),
        .hit       (hit),
        .dir_rd    (dir_rd),
        .aacc      (aacc_out),
        .dacc      (dacc_out),
        .drdy_o    (drdy_out),
        .oe        (ad_oe),
        .loc_wr    (loc_wr),
        .loc_rd    (loc_rd),
        .cap_w1    (cap_w1),
        .cap_w2    (cap_w2),
        .cap_wr    (cap_wr),
        .cap_rd    (cap_rd),
        .inc       (inc)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            loc_wdata <= '0;
            rdata_q   <= '0;
        end else begin
            if (cap_wr) loc_wdata <= ad_in;
            if (cap_rd) rdata_q   <= loc_rdata;
        end
    end

    assign ad_out = ad_oe ? rdata_q : '0;
endmodule

// File: rtl/mbs_slave_chk.sv
module mbs_slave_chk
    import mbs_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              addr_mode,
    input logic              drdy_in,
    input logic              dacc_in,
    input logic              loc_wait,
    input logic              aacc_out,
    input logic              dacc_out,
    input logic              drdy_out,
    input logic              ad_oe,
    input logic [BUS_W-1:0]  ad_out,
    input logic              loc_wr,
    input logic              loc_rd,
    input logic [ADDR_W-1:0] loc_addr
);
    p_aacc_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        aacc_out && drdy_in |=> aacc_out);
    p_aacc_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        aacc_out && !drdy_in |=> !aacc_out);
    p_ack_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dacc_out |-> !aacc_out && !drdy_out);
    p_dacc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dacc_out && drdy_in |=> dacc_out);
    p_dacc_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dacc_out && !drdy_in |=> !dacc_out);
    p_rd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        drdy_out && !dacc_in |=> drdy_out && ad_oe && $stable(ad_out));
    p_rd_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        drdy_out && dacc_in |=> !drdy_out && !ad_oe);
    p_rd_inc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        drdy_out && dacc_in |=> (loc_addr - $past(loc_addr)) == ADDR_W'(1));
    p_wr_inc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dacc_out && !drdy_in |=> (loc_addr - $past(loc_addr)) == ADDR_W'(1));
    p_wr_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        loc_wr && loc_wait |=> loc_wr && $stable(loc_addr) && !dacc_out);
    p_rd_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
        loc_rd && loc_wait && !addr_mode |=> loc_rd && !drdy_out);
endmodule

bind mbs_slave mbs_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_mode (addr_mode),
    .drdy_in   (drdy_in),
    .dacc_in   (dacc_in),
    .loc_wait  (loc_wait),
    .aacc_out  (aacc_out),
    .dacc_out  (dacc_out),
    .drdy_out  (drdy_out),
    .ad_oe     (ad_oe),
    .ad_out    (ad_out),
    .loc_wr    (loc_wr),
    .loc_rd    (loc_rd),
    .loc_addr  (loc_addr)
);

// File: tb/mbs_slave_tb.sv
module mbs_slave_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  dev_id = 4'd5;
    logic [15:0] ad_in = '0;
    logic [15:0] ad_out;
    logic        ad_oe;
    logic        addr_mode = 1'b1;
    logic        drdy_in = 1'b0;
    logic        drdy_out, aacc_out, dacc_out;
    logic        dacc_in = 1'b0;
    logic [23:0] loc_addr;
    logic        loc_space, loc_wr, loc_rd;
    logic [15:0] loc_wdata, loc_rdata;
    logic        loc_wait = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [15:0] mem [64];
    logic [23:0] last_wa;
    logic [15:0] last_wd;
    logic        last_sp;
    int          wr_cnt = 0;

    always #2 clk = ~clk;

    mbs_slave dut_i (
        .clk(clk), .rst_n(rst_n), .dev_id(dev_id), .ad_in(ad_in), .ad_out(ad_out),
        .ad_oe(ad_oe), .addr_mode(addr_mode), .drdy_in(drdy_in), .drdy_out(drdy_out),
        .aacc_out(aacc_out), .dacc_in(dacc_in), .dacc_out(dacc_out), .loc_addr(loc_addr),
        .loc_space(loc_space), .loc_wr(loc_wr), .loc_wdata(loc_wdata), .loc_rd(loc_rd),
        .loc_rdata(loc_rdata), .loc_wait(loc_wait)
    );

    // Stand-in local storage with a write log.
    assign loc_rdata = mem[loc_addr[5:0]];
    always @(posedge clk) begin
        if (loc_wr && !loc_wait) begin
            mem[loc_addr[5:0]] <= loc_wdata;
            last_wa <= loc_addr;
            last_wd <= loc_wdata;
            last_sp <= loc_space;
            wr_cnt  <= wr_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic addr_word(input logic [15:0] w);
        addr_mode = 1'b1; ad_in = w; drdy_in = 1'b1;
        @(negedge clk);
        chk(aacc_out === 1'b1, "R1 aacc one cycle after strobe", aacc_out, 1);
        @(negedge clk);
        chk(aacc_out === 1'b1, "R1 aacc held while strobe high", aacc_out, 1);
        drdy_in = 1'b0;
        @(negedge clk);
        chk(aacc_out === 1'b0, "R1 aacc released", aacc_out, 0);
    endtask

    task automatic select(input logic [3:0] dev, input bit sp, input bit rd, input logic [23:0] a);
        addr_mode = 1'b1;
        @(negedge clk);
        addr_word({a[23:16], dev, 2'b00, sp, rd});
        addr_word(a[15:0]);
        addr_mode = 1'b0; ad_in = '0;
        @(negedge clk);
    endtask

    task automatic deselect;
        addr_mode = 1'b1;
        @(negedge clk);
        addr_word(16'h00F0);
        addr_word(16'h0000);
        addr_mode = 1'b0;
        @(negedge clk);
    endtask

    task automatic mwrite(input logic [15:0] d, input bit expect_ack, input logic [23:0] exp_a, input string req);
        int n;
        int c0;
        c0 = wr_cnt;
        addr_mode = 1'b0; ad_in = d; drdy_in = 1'b1;
        n = 0;
        while (dacc_out !== 1'b1 && n < 8) begin @(negedge clk); n++; end
        if (expect_ack) begin
            chk(dacc_out === 1'b1 && n == 2, {req, " dacc two cycles after strobe"}, n, 2);
            drdy_in = 1'b0;
            @(negedge clk);
            chk(dacc_out === 1'b0, {req, " dacc released"}, dacc_out, 0);
            chk(last_wd == d, {req, " written data"}, last_wd, d);
            chk(last_wa == exp_a, {req, " written address"}, last_wa, exp_a);
        end else begin
            chk(dacc_out === 1'b0 && wr_cnt == c0, {req, " strobe ignored"}, wr_cnt - c0, 0);
            drdy_in = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic mread(input logic [15:0] exp_d, input logic [23:0] exp_a, input string req);
        int n;
        n = 0;
        while (drdy_out !== 1'b1 && n < 12) begin @(negedge clk); n++; end
        chk(drdy_out === 1'b1 && ad_oe === 1'b1, {req, " drdy_out and ad_oe"}, {drdy_out, ad_oe}, 2'b11);
        chk(ad_out == exp_d, {req, " read data"}, ad_out, exp_d);
        chk(loc_addr == exp_a, {req, " R8 read address"}, loc_addr, exp_a);
        @(negedge clk);
        chk(drdy_out === 1'b1 && ad_out == exp_d, {req, " held until dacc"}, ad_out, exp_d);
        dacc_in = 1'b1;
        @(negedge clk);
        chk(drdy_out === 1'b0 && ad_oe === 1'b0, {req, " released after dacc"}, {drdy_out, ad_oe}, 0);
        dacc_in = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk({aacc_out, dacc_out, drdy_out, ad_oe, loc_wr, loc_rd} == 6'b0, "R10 reset outputs",
            {aacc_out, dacc_out, drdy_out, ad_oe, loc_wr, loc_rd}, 0);
    endtask

    task automatic t_write_mem;
        select(4'd5, 1'b0, 1'b0, 24'h123408);
        chk(loc_addr == 24'h123408, "R4 start address", loc_addr, 24'h123408);
        mwrite(16'h1111, 1, 24'h123408, "R5");
        mwrite(16'h2222, 1, 24'h123409, "R8");
        mwrite(16'h3333, 1, 24'h12340A, "R8");
        chk(last_sp == 1'b0, "R4 memory space", last_sp, 0);
    endtask

    task automatic t_read;
        select(4'd5, 1'b0, 1'b1, 24'h123407);
        mread(16'h5A15, 24'h123407, "R6");
        mread(16'h1111, 24'h123408, "R6");
        mread(16'h2222, 24'h123409, "R6");
        addr_mode = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(drdy_out === 1'b0 && loc_rd === 1'b0, "R7 read stops on address mode", {drdy_out, loc_rd}, 0);
    endtask

    task automatic t_deselect;
        select(4'd5, 1'b0, 1'b0, 24'h000010);
        mwrite(16'hABCD, 1, 24'h000010, "R3 own number");
        deselect;
        mwrite(16'hDEAD, 0, 24'h0, "R3 after deselect");
    endtask

    task automatic t_other;
        select(4'd6, 1'b0, 1'b0, 24'h000011);
        mwrite(16'hBEEF, 0, 24'h0, "R3 other number");
    endtask

    task automatic t_partial;
        addr_mode = 1'b1;
        @(negedge clk);
        addr_word({8'h00, 4'd5, 4'b0000});
        addr_mode = 1'b0;
        @(negedge clk);
        mwrite(16'h0F0F, 0, 24'h0, "R2 one word only");
        addr_word(16'h0030);
        addr_mode = 1'b0;
        @(negedge clk);
        mwrite(16'h3030, 1, 24'h000030, "R2 both words");
    endtask

    task automatic t_space;
        select(4'd5, 1'b1, 1'b0, 24'h000020);
        mwrite(16'h7777, 1, 24'h000020, "R4");
        chk(last_sp == 1'b1, "R4 register space", last_sp, 1);
    endtask

    task automatic t_leave;
        select(4'd5, 1'b0, 1'b0, 24'h000018);
        mwrite(16'h1818, 1, 24'h000018, "R7");
        addr_mode = 1'b1;
        @(negedge clk);
        @(negedge clk);
        mwrite(16'h1919, 0, 24'h0, "R7 after address mode");
    endtask

    task automatic t_wait;
        int c0;
        int n;
        select(4'd5, 1'b0, 1'b0, 24'h000028);
        loc_wait = 1'b1;
        c0 = wr_cnt;
        ad_in = 16'h2828; drdy_in = 1'b1;
        repeat (5) @(negedge clk);
        chk(dacc_out === 1'b0 && loc_wr === 1'b1 && wr_cnt == c0, "R9 write held",
            {dacc_out, loc_wr}, 2'b01);
        chk(loc_addr == 24'h000028, "R9 address stable", loc_addr, 24'h000028);
        loc_wait = 1'b0;
        n = 0;
        while (dacc_out !== 1'b1 && n < 8) begin @(negedge clk); n++; end
        chk(dacc_out === 1'b1 && last_wd == 16'h2828, "R9 write after wait", last_wd, 16'h2828);
        drdy_in = 1'b0;
        @(negedge clk);
        select(4'd5, 1'b0, 1'b1, 24'h000028);
        loc_wait = 1'b1;
        repeat (6) @(negedge clk);
        chk(drdy_out === 1'b0 && loc_rd === 1'b1, "R9 read held", {drdy_out, loc_rd}, 2'b01);
        loc_wait = 1'b0;
        mread(16'h2828, 24'h000028, "R9");
        addr_mode = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 16'h5A00 + 16'(i * 3);
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_write_mem;
        t_read;
        t_deselect;
        t_other;
        t_partial;
        t_space;
        t_leave;
        t_wait;
        repeat (3) @(negedge clk);
        finish_run;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run;
    end
endmodule